// File: doc/BRIEF.md
# Serial Clock Source and SCK Pin Controller

This block owns the clocking side of a serial port that runs either as a UART or as a clocked synchronous link. From a mode bit and a two-bit clock-enable field it picks an internal baud tick or an external clock on the bidirectional SCK pin. It sets the pin direction and output level, and it hands the transmitter and receiver two single-cycle strobes in the bus-clock domain. The first strobe marks each sixteenth of a bit in asynchronous mode. The second marks each bit.

The same block holds the transmit-buffer-empty and transmit-end flags and raises the transmit-end interrupt. It also enforces the read-then-write sequence that software must follow to clear them. The shifter, the data path and the baud divider sit outside. The transmitter reports buffer refills and frame completion to this block through set pulses.

Top module: `sck_clk_ctrl`

## Requirements
- R1: After reset, sck_oe_o=0, sck_o=1, tdre_o=1, tend_o=1 and tei_o=0. The block is in asynchronous mode with the internal clock and clock-enable field 00.
- R2: Asynchronous mode with field 00 keeps the pin undriven (sck_oe_o=0, sck_o=1). os_stb_o pulses once per baud_tick_i, and bit_stb_o pulses on every 16th baud tick.
- R3: Asynchronous mode with field 01 drives the pin (sck_oe_o=1) with a square wave whose period is 16 baud ticks, 8 ticks low and 8 ticks high. The strobes are the same as in R2.
- R4: Synchronous mode with field bit 1 at 0 drives the pin, and sck_o toggles on every baud tick. bit_stb_o pulses once per low-to-high step of sck_o, and os_stb_o stays 0. Field bit 0 has no effect here.
- R5: Field bit 1 at 1 leaves the pin undriven (sck_oe_o=0, sck_o=1) in either mode, and baud ticks then give no strobes.
- R6: With an external clock in asynchronous mode, each rising edge of sck_i gives one os_stb_o pulse after a two-flop synchronizer, and every 16th such edge also gives bit_stb_o.
- R7: With an external clock in synchronous mode, each rising edge of sck_i gives one bit_stb_o pulse, and os_stb_o stays 0.
- R8: tei_o is 1 exactly when the interrupt enable is 1 and tend_o is 1. Writing the enable to 0 drops tei_o from the next cycle.
- R9: tdre_set_i sets tdre_o. tend_set_i sets tend_o only while tdre_o is 1.
- R10: A stat_rd_i pulse while tdre_o=1 arms the clear. A stat_wr_i pulse with stat_tdre_i=0 while armed clears both tdre_o and tend_o. Without the arm, the write has no effect. Every status write disarms.
- R11: While xfer_en_i=1, control writes leave the mode and clock-enable field unchanged, but the interrupt enable is still written.
- R12: Whenever sck_oe_o=0, sck_o is 1, so a change of mode gives no short pulse on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_sync_i | input | 1 | Mode to write: 1 synchronous, 0 asynchronous |
| ctrl_cke_i | input | 2 | Clock-enable field to write |
| ctrl_teie_i | input | 1 | Transmit-end interrupt enable to write |
| xfer_en_i | input | 1 | Transmitter or receiver enabled; locks the clock selection |
| baud_tick_i | input | 1 | Internal baud tick, one cycle wide |
| sck_i | input | 1 | SCK pin input |
| sck_o | output | 1 | SCK pin output value |
| sck_oe_o | output | 1 | SCK pin output enable |
| os_stb_o | output | 1 | Oversample strobe (asynchronous mode) |
| bit_stb_o | output | 1 | Bit strobe |
| tdre_set_i | input | 1 | Transmit buffer became empty |
| tend_set_i | input | 1 | Last bit of a frame shifted out |
| stat_rd_i | input | 1 | Status read strobe |
| stat_wr_i | input | 1 | Status write strobe |
| stat_tdre_i | input | 1 | Buffer-empty flag value written |
| tdre_o | output | 1 | Transmit-buffer-empty flag |
| tend_o | output | 1 | Transmit-end flag |
| tei_o | output | 1 | Transmit-end interrupt |

## Verification
The assertions assume single-cycle strobes on baud_tick_i, tdre_set_i, tend_set_i, stat_rd_i and stat_wr_i. They assume an external clock whose high and low phases each last at least two bus cycles, and they assume no set pulse lands in the same cycle as a clearing write. The stimulus drives every strobe for exactly one cycle and keeps sck_i phases at three cycles or more. It changes the clock selection only with xfer_en_i low, except in the scenario that checks the lock. It also keeps flag set pulses apart from status writes.

// File: rtl/sck_pkg.sv
package sck_pkg;

  typedef enum logic [1:0] {
    ROLE_INT_IO     = 2'd0,
    ROLE_INT_BITCLK = 2'd1,
    ROLE_INT_SERCLK = 2'd2,
    ROLE_EXT_IN     = 2'd3
  } sck_role_e;

  function automatic sck_role_e role_of(input logic sync, input logic [1:0] cke);
    if (cke[1]) return ROLE_EXT_IN;
    if (sync) return ROLE_INT_SERCLK;
    if (cke[0]) return ROLE_INT_BITCLK;
    return ROLE_INT_IO;
  endfunction

endpackage

// File: rtl/sck_edge_sync.sv
module sck_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= pin_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  p_rise_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sck_strobe_gen.sv
module sck_strobe_gen
  import sck_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sck_role_e role_i,
  input  logic      sync_i,
  input  logic      baud_tick_i,
  input  logic      ext_rise_i,
  output logic      os_stb_o,
  output logic      bit_stb_o,
  output logic      sck_o,
  output logic      sck_oe_o
);
  localparam int CNT_W = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OS_RATE - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OS_RATE / 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d, oe_q, oe_d;
  logic             ext, os_src;

  assign ext    = (role_i == ROLE_EXT_IN);
  assign os_src = ext ? ext_rise_i : baud_tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (sync_i)      cnt_d = '0;
    else if (os_src) cnt_d = (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    os_stb_o  = 1'b0;
    bit_stb_o = 1'b0;
    if (!sync_i) begin
      os_stb_o  = os_src;
      bit_stb_o = os_src && (cnt_q == CNT_MAX);
    end else if (ext) begin
      bit_stb_o = ext_rise_i;
    end else begin
      bit_stb_o = baud_tick_i && !sck_q;  // pin about to rise
    end
  end

  always_comb begin
    oe_d  = 1'b0;
    sck_d = 1'b1;  // idle high when not driven
    unique case (role_i)
      ROLE_INT_BITCLK: begin
        oe_d  = 1'b1;
        sck_d = (cnt_d >= CNT_HALF);
      end
      ROLE_INT_SERCLK: begin
        oe_d  = 1'b1;
        sck_d = baud_tick_i ? ~sck_q : sck_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
      oe_q  <= oe_d;
    end
  end

  assign sck_o    = sck_q;
  assign sck_oe_o = oe_q;

  p_idle_high_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_oe_o |-> sck_o);
  p_bit_in_os_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && bit_stb_o) |-> os_stb_o);
  p_sync_no_os_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && baud_tick_i && !ext) |-> !os_stb_o);

endmodule

// File: rtl/sck_tend_irq.sv
module sck_tend_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic teie_i,
  input  logic tdre_set_i,
  input  logic tend_set_i,
  input  logic stat_rd_i,
  input  logic stat_wr_i,
  input  logic stat_tdre_i,
  output logic tdre_o,
  output logic tend_o,
  output logic tei_o
);
  logic tdre_q, tend_q, armed_q, clr;

  assign clr = stat_wr_i && !stat_tdre_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdre_q  <= 1'b1;
      tend_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      if (stat_wr_i)                armed_q <= 1'b0;
      else if (stat_rd_i && tdre_q) armed_q <= 1'b1;

      if (tdre_set_i) tdre_q <= 1'b1;
      else if (clr)   tdre_q <= 1'b0;

      if (clr)                       tend_q <= 1'b0;
      else if (tend_set_i && tdre_q) tend_q <= 1'b1;
    end
  end

  assign tdre_o = tdre_q;
  assign tend_o = tend_q;
  assign tei_o  = teie_i && tend_q;

  p_clear_both_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !tdre_set_i && !tend_set_i) |=> (!tdre_o && !tend_o));
  p_unarmed_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !armed_q && !tdre_set_i) |=> (tdre_o == $past(tdre_o)));
  p_tend_needs_tdre_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tend_set_i && !tdre_o && !stat_wr_i) |=> (tend_o == $past(tend_o)));

endmodule

// File: rtl/sck_clk_ctrl.sv
module sck_clk_ctrl
  import sck_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic       ctrl_sync_i,
  input  logic [1:0] ctrl_cke_i,
  input  logic       ctrl_teie_i,
  input  logic       xfer_en_i,
  input  logic       baud_tick_i,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe_o,
  output logic       os_stb_o,
  output logic       bit_stb_o,
  input  logic       tdre_set_i,
  input  logic       tend_set_i,
  input  logic       stat_rd_i,
  input  logic       stat_wr_i,
  input  logic       stat_tdre_i,
  output logic       tdre_o,
  output logic       tend_o,
  output logic       tei_o
);
  logic       sync_q, teie_q, ext_rise;
  logic [1:0] cke_q;
  sck_role_e  role;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      cke_q  <= 2'b00;
      teie_q <= 1'b0;
    end else if (ctrl_we_i) begin
      teie_q <= ctrl_teie_i;
      if (!xfer_en_i) begin  // source locked while transferring
        sync_q <= ctrl_sync_i;
        cke_q  <= ctrl_cke_i;
      end
    end
  end

  assign role = role_of(sync_q, cke_q);

  sck_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (sck_i),
    .rise_o(ext_rise)
  );

  sck_strobe_gen #(.OS_RATE(OS_RATE)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .role_i     (role),
    .sync_i     (sync_q),
    .baud_tick_i(baud_tick_i),
    .ext_rise_i (ext_rise),
    .os_stb_o   (os_stb_o),
    .bit_stb_o  (bit_stb_o),
    .sck_o      (sck_o),
    .sck_oe_o   (sck_oe_o)
  );

  sck_tend_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .teie_i     (teie_q),
    .tdre_set_i (tdre_set_i),
    .tend_set_i (tend_set_i),
    .stat_rd_i  (stat_rd_i),
    .stat_wr_i  (stat_wr_i),
    .stat_tdre_i(stat_tdre_i),
    .tdre_o     (tdre_o),
    .tend_o     (tend_o),
    .tei_o      (tei_o)
  );

  p_lock_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && xfer_en_i) |=> ($stable(cke_q) && $stable(sync_q)));
  p_ext_undriven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_q[1] |=> !sck_oe_o);
  p_tei_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_teie_i) |=> !tei_o);

endmodule

// File: tb/sck_clk_ctrl_test.sv
`timescale 1ns/1ps
module sck_clk_ctrl_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ctrl_we_i = 0, ctrl_sync_i = 0, ctrl_teie_i = 0, xfer_en_i = 0;
  logic [1:0] ctrl_cke_i = 2'b00;
  logic baud_tick_i = 0, sck_i = 0;
  logic tdre_set_i = 0, tend_set_i = 0, stat_rd_i = 0, stat_wr_i = 0, stat_tdre_i = 0;
  logic sck_o, sck_oe_o, os_stb_o, bit_stb_o, tdre_o, tend_o, tei_o;

  int checks = 0, failures = 0;
  int n_os = 0, n_bit = 0, n_rise = 0, n_high = 0, n_samp = 0, n_oe = 0;
  logic prev_sck = 1'b1;
  bit done = 0;

  always #2 clk = ~clk;

  sck_clk_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_sync_i(ctrl_sync_i),
    .ctrl_cke_i(ctrl_cke_i), .ctrl_teie_i(ctrl_teie_i), .xfer_en_i(xfer_en_i),
    .baud_tick_i(baud_tick_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .os_stb_o(os_stb_o), .bit_stb_o(bit_stb_o), .tdre_set_i(tdre_set_i),
    .tend_set_i(tend_set_i), .stat_rd_i(stat_rd_i), .stat_wr_i(stat_wr_i),
    .stat_tdre_i(stat_tdre_i), .tdre_o(tdre_o), .tend_o(tend_o), .tei_o(tei_o)
  );

  always @(negedge clk) begin
    n_os   += int'(os_stb_o);
    n_bit  += int'(bit_stb_o);
    n_high += int'(sck_o);
    n_oe   += int'(sck_oe_o);
    n_samp += 1;
    if (sck_o && !prev_sck) n_rise += 1;
    prev_sck = sck_o;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clr_cnt();
    n_os = 0; n_bit = 0; n_rise = 0; n_high = 0; n_samp = 0; n_oe = 0;
  endtask

  task automatic wr_ctrl(input logic sync, input logic [1:0] cke, input logic teie);
    ctrl_we_i = 1; ctrl_sync_i = sync; ctrl_cke_i = cke; ctrl_teie_i = teie;
    cyc(1);
    ctrl_we_i = 0;
    cyc(4);
  endtask

  task automatic ticks(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      baud_tick_i = 1; cyc(1); baud_tick_i = 0; cyc(period - 1);
    end
    cyc(4);
  endtask

  task automatic ext_clk(input int n);
    for (int i = 0; i < n; i++) begin
      sck_i = 1; cyc(3); sck_i = 0; cyc(3);
    end
    cyc(5);
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  task automatic t_reset();
    check("R1 oe", int'(sck_oe_o), 0);
    check("R1 sck", int'(sck_o), 1);
    check("R1 tdre", int'(tdre_o), 1);
    check("R1 tend", int'(tend_o), 1);
    check("R1 tei", int'(tei_o), 0);
  endtask

  task automatic t_async_io();
    cyc(2); clr_cnt();
    ticks(32, 2);
    check("R2 os per tick", n_os, 32);
    check("R2 bit per 16", n_bit, 2);
    check("R2 undriven", n_oe, 0);
    check("R2 sck high", n_high, n_samp);
  endtask

  task automatic t_async_clkout();
    wr_ctrl(0, 2'b01, 0);
    check("R3 oe", int'(sck_oe_o), 1);
    clr_cnt();
    for (int i = 0; i < 32; i++) begin
      baud_tick_i = 1; cyc(1); baud_tick_i = 0; cyc(1);
    end
    check("R3 high half", n_high, 32);
    check("R3 rises", n_rise, 2);
    check("R3 bit", n_bit, 2);
    check("R3 os", n_os, 32);
  endtask

  task automatic t_sync_int(input logic [1:0] cke);
    wr_ctrl(1, cke, 0);
    check("R4 oe", int'(sck_oe_o), 1);
    clr_cnt();
    ticks(32, 3);
    check("R4 rises", n_rise, 16);
    check("R4 bit", n_bit, 16);
    check("R4 no os", n_os, 0);
  endtask

  task automatic t_ext_quiet(input logic sync);
    wr_ctrl(sync, 2'b11, 0);
    clr_cnt();
    ticks(20, 2);
    check("R5 undriven", n_oe, 0);
    check("R5 sck high", n_high, n_samp);
    check("R5 no os", n_os, 0);
    check("R5 no bit", n_bit, 0);
  endtask

  task automatic t_ext_async();
    wr_ctrl(0, 2'b10, 0);
    clr_cnt();
    ext_clk(32);
    check("R6 os per edge", n_os, 32);
    check("R6 bit per 16", n_bit, 2);
  endtask

  task automatic t_ext_sync();
    wr_ctrl(1, 2'b10, 0);
    clr_cnt();
    ext_clk(10);
    check("R7 bit per edge", n_bit, 10);
    check("R7 no os", n_os, 0);
  endtask

  task automatic t_lock();
    wr_ctrl(0, 2'b00, 0);
    xfer_en_i = 1;
    wr_ctrl(0, 2'b01, 1);
    check("R11 source kept", int'(sck_oe_o), 0);
    check("R11 enable written", int'(tei_o), 1);
    xfer_en_i = 0;
    wr_ctrl(0, 2'b00, 1);
  endtask

  task automatic t_handshake();
    stat_tdre_i = 0; pulse(stat_wr_i);
    check("R10 unarmed tdre", int'(tdre_o), 1);
    check("R10 unarmed tei", int'(tei_o), 1);
    pulse(stat_rd_i); stat_tdre_i = 1; pulse(stat_wr_i);
    check("R10 write one", int'(tdre_o), 1);
    stat_tdre_i = 0; pulse(stat_wr_i);
    check("R10 disarmed", int'(tdre_o), 1);
    pulse(stat_rd_i); pulse(stat_wr_i);
    check("R10 clr tdre", int'(tdre_o), 0);
    check("R10 clr tend", int'(tend_o), 0);
    check("R8 tei low", int'(tei_o), 0);
    pulse(tend_set_i);
    check("R9 tend blocked", int'(tend_o), 0);
    pulse(stat_rd_i); pulse(tdre_set_i);
    check("R9 tdre set", int'(tdre_o), 1);
    pulse(stat_wr_i);
    check("R10 read at zero", int'(tdre_o), 1);
    pulse(tend_set_i);
    check("R9 tend set", int'(tend_o), 1);
    check("R8 tei high", int'(tei_o), 1);
    ctrl_we_i = 1; ctrl_teie_i = 0; ctrl_cke_i = 2'b00; ctrl_sync_i = 0;
    cyc(1); ctrl_we_i = 0;
    check("R8 enable off", int'(tei_o), 0);
    check("R8 tend kept", int'(tend_o), 1);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(1);
    t_reset();
    t_async_io();
    t_async_clkout();
    t_sync_int(2'b00);
    t_sync_int(2'b01);
    t_ext_quiet(0);
    t_ext_quiet(1);
    t_ext_async();
    t_ext_sync();
    check("R12 back to idle", int'(sck_o), 1);
    t_lock();
    t_handshake();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule